// File: doc/BRIEF.md
# Sample Word to Byte Stream Packetizer

This block sits between a converter-side path that carries 24-bit sample words and a host link that carries bytes. It has two directions that run independently. In the outbound direction it takes one word from a word source queue and writes it into a byte queue as three bytes, one per cycle. The most significant byte goes first. In the inbound direction it takes three bytes from a byte queue, rebuilds the word from them in the same order, and writes the word towards the converter side.

Each direction is a short fixed-order state machine. Every read enable and write enable belongs to one state. Both source queues are show-ahead: the head entry is on the data pins whenever the queue is not empty, and a read enable sampled high at a clock edge removes that entry at the same edge. The outbound byte queue reports how many entries it has free, as well as a full flag. The reset input is asynchronous and active low. It takes effect at once and is released in step with the clock.

Top module: `word_byte_packer`

## Requirements
- R1: While reset is asserted, and after reset while all queues are empty, every enable output is low and every data output is zero.
- R2: Each word read from the source (show-ahead, consumed by `src_rd_en`) is written out as exactly three bytes in the order bits 23:16, bits 15:8, bits 7:0. Words go out in the order they were read.
- R3: The outbound side does not read the source while the source is empty, or while `tx_free` is less than 3. A word that arrives under those conditions stays in the source queue.
- R4: No outbound byte is written while `tx_full` is high. After `tx_full` falls, the byte that was held back is the next one written, and the word is completed with no byte lost or repeated.
- R5: `src_rd_en` and `tx_wr_en` are never high in the same cycle. `src_rd_en` is never high in two consecutive cycles. `tx_data` is zero whenever `tx_wr_en` is low.
- R6: The inbound side rebuilds a word from three consecutive bytes of the byte queue. The first byte becomes bits 23:16 and the third becomes bits 7:0.
- R7: `rx_rd_en` is high only when `rx_empty` is low. When fewer than three bytes are available, the bytes already read are kept and no word is written until the missing byte arrives.
- R8: `daq_data` is zero whenever `daq_wr_en` is low. No word is written while `daq_full` is high, and the pending word is written once `daq_full` falls.
- R9: If the byte queue never becomes full, the three bytes of a word are written in three consecutive clock cycles.
- R10: Outbound and inbound traffic that occur at the same time both complete correctly, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| src_empty | input | 1 | Word source queue has no entry |
| src_data | input | 24 | Head word of the source queue (show-ahead) |
| src_rd_en | output | 1 | Removes the head word from the source queue |
| tx_free | input | 8 | Number of free entries in the outbound byte queue |
| tx_full | input | 1 | Outbound byte queue is full |
| tx_wr_en | output | 1 | Writes `tx_data` into the outbound byte queue |
| tx_data | output | 8 | Outbound byte; zero when not writing |
| rx_empty | input | 1 | Inbound byte queue has no entry |
| rx_data | input | 8 | Head byte of the inbound byte queue (show-ahead) |
| rx_rd_en | output | 1 | Removes the head byte from the inbound byte queue |
| daq_full | input | 1 | Converter-side word sink cannot accept a word |
| daq_wr_en | output | 1 | Writes `daq_data` to the converter side |
| daq_data | output | 24 | Rebuilt word; zero when not writing |

## Verification
The hardest cases to reach are those where the flow stops partway through a word. One is a full byte queue after only the first byte of a word has gone out. The other is an inbound queue that runs dry after two of the three bytes. The bench waits for the first outbound byte to appear, then raises the full flag on the next falling edge, before the second byte's edge. For the inbound case it loads only two bytes, waits well past the normal word time, and then supplies the third. In both cases it checks that nothing moved while the flow was stopped and that the finished word is correct.

// File: rtl/wbp_pkg.sv
`timescale 1ns/1ps
package wbp_pkg;

  localparam int unsigned BYTES_PER_WORD = 3;

  typedef enum logic [2:0] {
    O_IDLE = 3'd0,
    O_READ = 3'd1,
    O_PKT1 = 3'd2,
    O_PKT2 = 3'd3,
    O_PKT3 = 3'd4
  } out_state_t;

  typedef enum logic [2:0] {
    I_IDLE  = 3'd0,
    I_PREP  = 3'd1,
    I_RD1   = 3'd2,
    I_RD2   = 3'd3,
    I_RD3   = 3'd4,
    I_REASM = 3'd5,
    I_WRITE = 3'd6
  } in_state_t;

endpackage

// File: rtl/wbp_rst_sync.sv
`timescale 1ns/1ps
module wbp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wbp_split.sv
`timescale 1ns/1ps
module wbp_split
  import wbp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned FREE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_empty,
  input  logic [BYTE_W*BYTES_PER_WORD-1:0] src_data,
  output logic                src_rd_en,
  input  logic [FREE_W-1:0]   tx_free,
  input  logic                tx_full,
  output logic                tx_wr_en,
  output logic [BYTE_W-1:0]   tx_data
);

  localparam int unsigned WORD_W = BYTE_W * BYTES_PER_WORD;
  localparam int unsigned IDX_W  = $clog2(BYTES_PER_WORD);
  localparam logic [FREE_W-1:0] ROOM_NEEDED = FREE_W'(BYTES_PER_WORD);

  out_state_t          state_q, state_d;
  logic [WORD_W-1:0]   word_q;
  logic                word_ld;
  logic [IDX_W-1:0]    lane_idx;
  logic [BYTE_W-1:0]   lane [BYTES_PER_WORD];

  // lane 0 is the most significant byte and leaves first
  for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_lane
    assign lane[g] = word_q[WORD_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    state_d   = state_q;
    src_rd_en = 1'b0;
    tx_wr_en  = 1'b0;
    lane_idx  = '0;
    unique case (state_q)
      O_IDLE: begin
        if (!src_empty && (tx_free >= ROOM_NEEDED)) state_d = O_READ;
      end
      O_READ: begin
        src_rd_en = 1'b1;
        state_d   = O_PKT1;
      end
      O_PKT1: begin
        lane_idx = IDX_W'(0);
        if (!tx_full) begin
          tx_wr_en = 1'b1;
          state_d  = O_PKT2;
        end
      end
      O_PKT2: begin
        lane_idx = IDX_W'(1);
        if (!tx_full) begin
          tx_wr_en = 1'b1;
          state_d  = O_PKT3;
        end
      end
      O_PKT3: begin
        lane_idx = IDX_W'(2);
        if (!tx_full) begin
          tx_wr_en = 1'b1;
          state_d  = O_IDLE;
        end
      end
      default: state_d = O_IDLE;
    endcase
  end

  assign word_ld = src_rd_en;
  assign tx_data = tx_wr_en ? lane[lane_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= O_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_ld) begin
      word_q <= src_data;
    end
  end

endmodule

// File: rtl/wbp_join.sv
`timescale 1ns/1ps
module wbp_join
  import wbp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_empty,
  input  logic [BYTE_W-1:0]   rx_data,
  output logic                rx_rd_en,
  input  logic                daq_full,
  output logic                daq_wr_en,
  output logic [BYTE_W*BYTES_PER_WORD-1:0] daq_data
);

  localparam int unsigned WORD_W = BYTE_W * BYTES_PER_WORD;
  localparam int unsigned IDX_W  = $clog2(BYTES_PER_WORD);

  in_state_t            state_q, state_d;
  logic [IDX_W-1:0]     slot_idx;
  logic [BYTE_W-1:0]    byte_q [BYTES_PER_WORD];
  logic [WORD_W-1:0]    word_d, word_q;
  logic                 word_ld;

  always_comb begin
    state_d   = state_q;
    rx_rd_en  = 1'b0;
    daq_wr_en = 1'b0;
    word_ld   = 1'b0;
    slot_idx  = '0;
    unique case (state_q)
      I_IDLE: begin
        if (!rx_empty) state_d = I_PREP;
      end
      I_PREP: begin
        state_d = I_RD1;
      end
      I_RD1: begin
        slot_idx = IDX_W'(0);
        if (!rx_empty) begin
          rx_rd_en = 1'b1;
          state_d  = I_RD2;
        end
      end
      I_RD2: begin
        slot_idx = IDX_W'(1);
        if (!rx_empty) begin
          rx_rd_en = 1'b1;
          state_d  = I_RD3;
        end
      end
      I_RD3: begin
        slot_idx = IDX_W'(2);
        if (!rx_empty) begin
          rx_rd_en = 1'b1;
          state_d  = I_REASM;
        end
      end
      I_REASM: begin
        word_ld = 1'b1;
        state_d = I_WRITE;
      end
      I_WRITE: begin
        if (!daq_full) begin
          daq_wr_en = 1'b1;
          state_d   = I_IDLE;
        end
      end
      default: state_d = I_IDLE;
    endcase
  end

  // one holding register per byte slot; slot 0 lands in the top bits
  for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_slot
    logic slot_ld;
    assign slot_ld = rx_rd_en && (slot_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[g] <= '0;
      end else if (slot_ld) begin
        byte_q[g] <= rx_data;
      end
    end

    assign word_d[WORD_W-1-g*BYTE_W -: BYTE_W] = byte_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= I_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_ld) begin
      word_q <= word_d;
    end
  end

  assign daq_data = daq_wr_en ? word_q : '0;

endmodule

// File: rtl/word_byte_packer.sv
`timescale 1ns/1ps
module word_byte_packer
  import wbp_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned FREE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                src_empty,
  input  logic [BYTE_W*BYTES_PER_WORD-1:0] src_data,
  output logic                src_rd_en,
  input  logic [FREE_W-1:0]   tx_free,
  input  logic                tx_full,
  output logic                tx_wr_en,
  output logic [BYTE_W-1:0]   tx_data,
  input  logic                rx_empty,
  input  logic [BYTE_W-1:0]   rx_data,
  output logic                rx_rd_en,
  input  logic                daq_full,
  output logic                daq_wr_en,
  output logic [BYTE_W*BYTES_PER_WORD-1:0] daq_data
);

  logic rst_n;

  wbp_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  wbp_split #(
    .BYTE_W (BYTE_W),
    .FREE_W (FREE_W)
  ) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_empty (src_empty),
    .src_data  (src_data),
    .src_rd_en (src_rd_en),
    .tx_free   (tx_free),
    .tx_full   (tx_full),
    .tx_wr_en  (tx_wr_en),
    .tx_data   (tx_data)
  );

  wbp_join #(
    .BYTE_W (BYTE_W)
  ) u_join (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_empty  (rx_empty),
    .rx_data   (rx_data),
    .rx_rd_en  (rx_rd_en),
    .daq_full  (daq_full),
    .daq_wr_en (daq_wr_en),
    .daq_data  (daq_data)
  );

endmodule

// File: rtl/wbp_checker.sv
`timescale 1ns/1ps
module wbp_checker #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_empty,
  input logic              src_rd_en,
  input logic              tx_full,
  input logic              tx_wr_en,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_empty,
  input logic              rx_rd_en,
  input logic              daq_full,
  input logic              daq_wr_en,
  input logic [WORD_W-1:0] daq_data
);

  p_no_src_read_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_empty |-> !src_rd_en);

  p_no_write_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_wr_en);

  p_exclusive_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_rd_en && tx_wr_en));

  p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |=> !src_rd_en);

  p_quiet_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr_en |-> (tx_data == '0));

  p_no_rx_read_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_rd_en);

  p_quiet_daq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !daq_wr_en |-> (daq_data == '0));

  p_no_daq_write_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    daq_full |-> !daq_wr_en);

endmodule

bind word_byte_packer wbp_checker #(
  .BYTE_W (BYTE_W),
  .WORD_W (BYTE_W * wbp_pkg::BYTES_PER_WORD)
) u_wbp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_empty (src_empty),
  .src_rd_en (src_rd_en),
  .tx_full   (tx_full),
  .tx_wr_en  (tx_wr_en),
  .tx_data   (tx_data),
  .rx_empty  (rx_empty),
  .rx_rd_en  (rx_rd_en),
  .daq_full  (daq_full),
  .daq_wr_en (daq_wr_en),
  .daq_data  (daq_data)
);

// File: tb/tb_word_byte_packer.sv
`timescale 1ns/1ps
module tb_word_byte_packer;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        arst_n;
  logic        src_empty;
  logic [23:0] src_data;
  logic        src_rd_en;
  logic [7:0]  tx_free;
  logic        tx_full;
  logic        tx_wr_en;
  logic [7:0]  tx_data;
  logic        rx_empty;
  logic [7:0]  rx_data;
  logic        rx_rd_en;
  logic        daq_full;
  logic        daq_wr_en;
  logic [23:0] daq_data;

  word_byte_packer dut (
    .clk(clk), .arst_n(arst_n),
    .src_empty(src_empty), .src_data(src_data), .src_rd_en(src_rd_en),
    .tx_free(tx_free), .tx_full(tx_full), .tx_wr_en(tx_wr_en), .tx_data(tx_data),
    .rx_empty(rx_empty), .rx_data(rx_data), .rx_rd_en(rx_rd_en),
    .daq_full(daq_full), .daq_wr_en(daq_wr_en), .daq_data(daq_data)
  );

  int n_checks = 0;
  int n_errors = 0;

  // show-ahead source queue models
  logic [23:0] src_mem [64];
  int src_wp = 0, src_rp = 0;
  assign src_empty = (src_wp == src_rp);
  assign src_data  = src_mem[src_rp % 64];

  logic [7:0] rxq_mem [64];
  int rxq_wp = 0, rxq_rp = 0;
  assign rx_empty = (rxq_wp == rxq_rp);
  assign rx_data  = rxq_mem[rxq_rp % 64];

  // sinks and port monitors
  logic [7:0]  txb_mem [64];
  int          txb_cyc [64];
  int          txb_cnt = 0;
  logic [23:0] daq_mem [64];
  int          daq_cnt = 0;
  int          cyc = 0;
  int          mon_r4 = 0, mon_r5 = 0, mon_r7 = 0, mon_r8 = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arst_n) begin
      if (src_rd_en && !src_empty) src_rp <= src_rp + 1;
      if (rx_rd_en && !rx_empty)   rxq_rp <= rxq_rp + 1;
      if (tx_wr_en) begin
        txb_mem[txb_cnt % 64] <= tx_data;
        txb_cyc[txb_cnt % 64] <= cyc;
        txb_cnt <= txb_cnt + 1;
      end
      if (daq_wr_en) begin
        daq_mem[daq_cnt % 64] <= daq_data;
        daq_cnt <= daq_cnt + 1;
      end
      if (tx_full && tx_wr_en) mon_r4 <= mon_r4 + 1;
      if ((src_rd_en && tx_wr_en) || (!tx_wr_en && tx_data != 8'h00)) mon_r5 <= mon_r5 + 1;
      if (rx_empty && rx_rd_en) mon_r7 <= mon_r7 + 1;
      if ((!daq_wr_en && daq_data != 24'h0) || (daq_full && daq_wr_en)) mon_r8 <= mon_r8 + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(input logic [23:0] w);
    @(negedge clk);
    src_mem[src_wp % 64] = w;
    src_wp++;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    rxq_mem[rxq_wp % 64] = b;
    rxq_wp++;
  endtask

  task automatic t_reset;
    arst_n = 1'b0; tx_free = 8'd16; tx_full = 1'b0; daq_full = 1'b0;
    wait_cyc(3);
    check(!src_rd_en && !tx_wr_en && !rx_rd_en && !daq_wr_en, "R1 enables in reset",
          {28'h0, src_rd_en, tx_wr_en, rx_rd_en, daq_wr_en}, 32'h0);
    check(tx_data == 8'h0 && daq_data == 24'h0, "R1 data in reset", {tx_data, daq_data}, 32'h0);
    arst_n = 1'b1;
    wait_cyc(6);
    check(!src_rd_en && !tx_wr_en && !rx_rd_en && !daq_wr_en && txb_cnt == 0 && daq_cnt == 0,
          "R1 idle after reset", txb_cnt + daq_cnt, 32'h0);
  endtask

  task automatic t_out_basic;
    int base = txb_cnt;
    logic [7:0] exp [6] = '{8'hA1, 8'hB2, 8'hC3, 8'h12, 8'h34, 8'h56};
    push_word(24'hA1B2C3);
    push_word(24'h123456);
    wait_cyc(16);
    check(txb_cnt - base == 6, "R2 byte count", txb_cnt - base, 6);
    for (int i = 0; i < 6; i++)
      check(txb_mem[(base + i) % 64] == exp[i], "R2 byte order", txb_mem[(base + i) % 64], exp[i]);
    check(src_rp == src_wp, "R2 source drained", src_rp, src_wp);
    for (int w = 0; w < 2; w++) begin
      int c0 = txb_cyc[(base + 3*w) % 64];
      check(txb_cyc[(base + 3*w + 1) % 64] == c0 + 1 && txb_cyc[(base + 3*w + 2) % 64] == c0 + 2,
            "R9 consecutive byte cycles", txb_cyc[(base + 3*w + 2) % 64] - c0, 2);
    end
  endtask

  task automatic t_out_hold;
    int base = txb_cnt;
    wait_cyc(6);
    check(txb_cnt == base, "R3 no output with empty source", txb_cnt - base, 0);
    tx_free = 8'd2;
    push_word(24'h5A6B7C);
    wait_cyc(10);
    check(txb_cnt == base, "R3 no output with low room", txb_cnt - base, 0);
    check(src_rp != src_wp, "R3 word left in source", src_wp - src_rp, 1);
    tx_free = 8'd3;
    wait_cyc(8);
    check(txb_cnt - base == 3, "R3 released at room 3", txb_cnt - base, 3);
    check(txb_mem[base % 64] == 8'h5A && txb_mem[(base + 2) % 64] == 8'h7C, "R3 released bytes",
          {txb_mem[base % 64], txb_mem[(base + 2) % 64]}, 16'h5A7C);
    tx_free = 8'd16;
  endtask

  task automatic t_out_stall;
    int base = txb_cnt;
    int guard = 0;
    push_word(24'h0F1E2D);
    while (txb_cnt == base && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    tx_full = 1'b1;
    wait_cyc(7);
    check(txb_cnt - base == 1, "R4 held while full", txb_cnt - base, 1);
    tx_full = 1'b0;
    wait_cyc(6);
    check(txb_cnt - base == 3, "R4 completes after full", txb_cnt - base, 3);
    check({txb_mem[base % 64], txb_mem[(base + 1) % 64], txb_mem[(base + 2) % 64]} == 24'h0F1E2D,
          "R4 bytes across stall",
          {txb_mem[base % 64], txb_mem[(base + 1) % 64], txb_mem[(base + 2) % 64]}, 24'h0F1E2D);
  endtask

  task automatic t_in_basic;
    int base = daq_cnt;
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    push_byte(8'hDE); push_byte(8'hAD); push_byte(8'hBE);
    wait_cyc(24);
    check(daq_cnt - base == 2, "R6 word count", daq_cnt - base, 2);
    check(daq_mem[base % 64] == 24'h112233, "R6 first word", daq_mem[base % 64], 24'h112233);
    check(daq_mem[(base + 1) % 64] == 24'hDEADBE, "R6 second word", daq_mem[(base + 1) % 64], 24'hDEADBE);
  endtask

  task automatic t_in_starve;
    int base = daq_cnt;
    push_byte(8'hC0); push_byte(8'hFF);
    wait_cyc(14);
    check(daq_cnt == base, "R7 no word from two bytes", daq_cnt - base, 0);
    check(rxq_rp == rxq_wp, "R7 two bytes taken", rxq_wp - rxq_rp, 0);
    push_byte(8'hEE);
    wait_cyc(8);
    check(daq_cnt - base == 1 && daq_mem[base % 64] == 24'hC0FFEE, "R7 word after late byte",
          daq_mem[base % 64], 24'hC0FFEE);
  endtask

  task automatic t_in_daqfull;
    int base = daq_cnt;
    daq_full = 1'b1;
    push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
    wait_cyc(16);
    check(daq_cnt == base, "R8 held while full", daq_cnt - base, 0);
    daq_full = 1'b0;
    wait_cyc(3);
    check(daq_cnt - base == 1 && daq_mem[base % 64] == 24'h010203, "R8 word after full",
          daq_mem[base % 64], 24'h010203);
  endtask

  task automatic t_concurrent;
    int tb = txb_cnt;
    int db = daq_cnt;
    @(negedge clk);
    src_mem[src_wp % 64] = 24'h778899; src_wp++;
    rxq_mem[rxq_wp % 64] = 8'hAB; rxq_wp++;
    rxq_mem[rxq_wp % 64] = 8'hCD; rxq_wp++;
    rxq_mem[rxq_wp % 64] = 8'hEF; rxq_wp++;
    wait_cyc(16);
    check(txb_cnt - tb == 3 &&
          {txb_mem[tb % 64], txb_mem[(tb + 1) % 64], txb_mem[(tb + 2) % 64]} == 24'h778899,
          "R10 outbound beside inbound",
          {txb_mem[tb % 64], txb_mem[(tb + 1) % 64], txb_mem[(tb + 2) % 64]}, 24'h778899);
    check(daq_cnt - db == 1 && daq_mem[db % 64] == 24'hABCDEF, "R10 inbound beside outbound",
          daq_mem[db % 64], 24'hABCDEF);
  endtask

  task automatic t_monitors;
    check(mon_r4 == 0, "R4 write while full seen", mon_r4, 0);
    check(mon_r5 == 0, "R5 enable overlap or stray byte", mon_r5, 0);
    check(mon_r7 == 0, "R7 read while empty seen", mon_r7, 0);
    check(mon_r8 == 0, "R8 stray word data or write while full", mon_r8, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_out_basic();
    t_out_hold();
    t_out_stall();
    t_in_basic();
    t_in_starve();
    t_in_daqfull();
    t_concurrent();
    t_monitors();
    finish_run();
  end

endmodule